// File: doc/BRIEF.md
# Prioritised Edge/Level Interrupt Handler

The block collects 32 interrupt request lines into one pending vector and forwards them to a processor as two requests: a normal interrupt (`irq_out`) and a fast interrupt (`fiq_out`). Each line has its own configuration word. The word holds a 5-bit priority, a sensitivity bit that selects edge or level capture, and a steering bit that routes the line to the fast or the normal request. A mask register removes lines from arbitration without discarding their pending state.

Each output works by agreement. While an agreement is open and some unmasked line of that class is pending, the block latches the winning line number as that class's code and raises the output. The output and the code then stay fixed until software opens a new agreement through the control register. Software learns the winner by reading the code register. That read also acknowledges an edge-type winner by clearing its pending bit. A software-trigger register lets software raise one line by hand.

All register accesses are 32-bit words with an 8-bit byte offset. The bus is a single-cycle strobe interface: `rdata` is combinational, and read and write side effects take place at the clock edge that ends the strobe.

Top module: `intr_handler`

## Requirements
- R1: After reset, the pending register (0x00) reads 0 and the mask register (0x04) reads all ones. Every configuration word reads 0, and `irq_out` and `fiq_out` are low.
- R2: An edge line (sensitivity bit 0) sets its pending bit only when its input goes from low to high. The bit stays set after the input falls. If the bit is cleared while the input is still high, it does not set again until the next rising edge.
- R3: A level line (sensitivity bit 1) has its pending bit set in every cycle that its input is high, and cleared in every cycle that its input is low.
- R4: A write to the pending register ANDs the written value into the pending bits. A bit whose line is level-sensitive and whose input is high keeps its value.
- R5: Among the pending, unmasked lines of one class (steering bit 0 = normal, 1 = fast), the lowest priority value wins. On a tie, the highest line number wins. Masked lines never win.
- R6: While the class agreement is open and an eligible line exists, the output rises at the next clock edge and the winner is latched as the code. Output and code then hold until control register 0x18 is written with bit 0 (normal) or bit 1 (fast). That write drops the output and reopens the agreement. The control register reads 0.
- R7: Reading 0x10 returns the latched normal code and reading 0x14 returns the latched fast code. The read clears that line's pending bit if the line is edge-sensitive and leaves it set if the line is level-sensitive. A rising edge on the same line in the same cycle takes precedence and keeps the bit set.
- R8: A write to 0x9C sets the pending bit of only the lowest set bit of the written value. The register reads 0.
- R9: The configuration word of line n lives at 0x1C + 4n. Its fields are bits [6:2] priority, bit 1 sensitivity and bit 0 steering, and it reads back as written. Writes to 0x10 and 0x14 are ignored, and undefined offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (enables read side effects) |
| addr | input | 8 | Byte offset of the accessed word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| irq_out | output | 1 | Normal interrupt request to the processor |
| fiq_out | output | 1 | Fast interrupt request to the processor |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the acknowledge performed by a code-register read and a fresh rising edge on the winning line. The bench raises the input of an already-latched edge winner in the very cycle it strobes the code read, and then requires the pending bit to survive. A second plain read is then required to clear it. The second pair is a write-zero to the pending register and a level input that is still high. The bench issues the clear while holding the input and requires the bit to remain. Around these cases, sweeps over every line and several priority, steering and mask patterns drain each class one agreement at a time. Each drain is compared against a winner computed in the bench.

// File: rtl/intr_handler.sv
module intr_handler #(
  parameter int NLINES = 32,
  parameter int PRIO_W = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_out,
  output logic              fiq_out
);
  localparam int LW = $clog2(NLINES);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_NCOD = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_FCOD = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_CFG0 = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_CFGN = ADDR_W'(8'h1C + 4 * (NLINES - 1));
  localparam logic [ADDR_W-1:0] A_SWTR = ADDR_W'(8'h9C);

  logic [NLINES-1:0] pend, pend_nx, in_q, mask, sens, steer;
  logic [PRIO_W-1:0] prio [NLINES];
  logic [LW-1:0]     ncode, fcode, nwin, fwin;
  logic              nopen, fopen;

  logic [ADDR_W-1:0] cfg_off;
  logic [LW-1:0]     cfg_idx;
  logic              cfg_hit;
  assign cfg_off = addr - A_CFG0;
  assign cfg_idx = cfg_off[LW+1:2];
  assign cfg_hit = (addr >= A_CFG0) && (addr <= A_CFGN) && (addr[1:0] == 2'b00);

  logic [NLINES-1:0] elig_n, elig_f, sw_bit;
  assign elig_n = pend & ~mask & ~steer;
  assign elig_f = pend & ~mask & steer;
  assign sw_bit = (wr_en && addr == A_SWTR) ? (wdata[NLINES-1:0] & (~wdata[NLINES-1:0] + 1'b1)) : '0;

  logic ctrl_wr;
  assign ctrl_wr = wr_en && addr == A_CTRL;

  always_comb begin
    logic [PRIO_W-1:0] bn, bf;
    bn = '1; bf = '1; nwin = '0; fwin = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (elig_n[i] && prio[i] <= bn) begin bn = prio[i]; nwin = LW'(i); end
      if (elig_f[i] && prio[i] <= bf) begin bf = prio[i]; fwin = LW'(i); end
    end
  end

  always_comb begin
    pend_nx = pend;
    if (wr_en && addr == A_PEND) pend_nx = pend_nx & (wdata[NLINES-1:0] | (irq_in & sens));
    if (rd_en && addr == A_NCOD && !sens[ncode]) pend_nx[ncode] = 1'b0;
    if (rd_en && addr == A_FCOD && !sens[fcode]) pend_nx[fcode] = 1'b0;
    pend_nx = pend_nx | (irq_in & ~in_q & ~sens) | (irq_in & sens) | sw_bit;
    pend_nx = pend_nx & ~(sens & ~irq_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0; in_q <= '0; mask <= '1; sens <= '0; steer <= '0;
      for (int i = 0; i < NLINES; i++) prio[i] <= '0;
      ncode <= '0; fcode <= '0; nopen <= 1'b1; fopen <= 1'b1;
      irq_out <= 1'b0; fiq_out <= 1'b0;
    end else begin
      pend <= pend_nx;
      in_q <= irq_in;
      if (wr_en && addr == A_MASK) mask <= wdata[NLINES-1:0];
      if (wr_en && cfg_hit) begin
        prio[cfg_idx]  <= wdata[PRIO_W+1:2];
        sens[cfg_idx]  <= wdata[1];
        steer[cfg_idx] <= wdata[0];
      end
      if (ctrl_wr && wdata[0]) begin
        irq_out <= 1'b0; nopen <= 1'b1;
      end else if (nopen && |elig_n) begin
        irq_out <= 1'b1; nopen <= 1'b0; ncode <= nwin;
      end
      if (ctrl_wr && wdata[1]) begin
        fiq_out <= 1'b0; fopen <= 1'b1;
      end else if (fopen && |elig_f) begin
        fiq_out <= 1'b1; fopen <= 1'b0; fcode <= fwin;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (cfg_hit) rdata = DATA_W'({prio[cfg_idx], sens[cfg_idx], steer[cfg_idx]});
    else case (addr)
      A_PEND: rdata = DATA_W'(pend);
      A_MASK: rdata = DATA_W'(mask);
      A_NCOD: rdata = DATA_W'(ncode);
      A_FCOD: rdata = DATA_W'(fcode);
      default: rdata = '0;
    endcase
  end

  AST_LEVEL_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend & $past(sens) & ~$past(irq_in)) == '0)); // R3
  AST_IRQ_RISE_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(|(pend & ~mask & ~steer))); // R6
  AST_FIQ_RISE_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_out) |-> $past(|(pend & ~mask & steer))); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !(ctrl_wr && wdata[0])) |=> (irq_out && $stable(ncode))); // R6
  AST_FIQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_out && !(ctrl_wr && wdata[1])) |=> (fiq_out && $stable(fcode))); // R6
  AST_SWTRIG_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SWTR) |-> $onehot0(sw_bit)); // R8
endmodule

// File: tb/intr_handler_tb.sv
module intr_handler_tb;
  localparam int CLK_NS = 10;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [31:0] irq_in = '0, wdata = '0, rdata;
  logic [7:0] addr = '0;
  logic irq_out, fiq_out;
  int total = 0, bad = 0;
  int bp [32];
  logic [31:0] bst;

  intr_handler u_dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .fiq_out(fiq_out));

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse(input logic [31:0] p);
    @(negedge clk); irq_in = p;
    @(negedge clk); irq_in = '0;
    @(negedge clk);
  endtask

  function automatic int pick(input logic [31:0] e);
    int best = 32, w = 0;
    for (int i = 0; i < 32; i++) if (e[i] && bp[i] <= best) begin best = bp[i]; w = i; end
    return w;
  endfunction

  task automatic drain(input bit fast, inout logic [31:0] mp, input logic [31:0] mk);
    logic [31:0] d, e;
    e = mp & ~mk & (fast ? bst : ~bst);
    while (e != 0) begin
      int w = pick(e);
      check(fast ? "R6 fiq_out" : "R6 irq_out", {31'b0, fast ? fiq_out : irq_out}, 1);
      rd(fast ? 8'h14 : 8'h10, d);
      check("R5 winner", d, w);
      mp[w] = 1'b0;
      wr(8'h18, fast ? 32'h2 : 32'h1);
      @(negedge clk);
      e = mp & ~mk & (fast ? bst : ~bst);
    end
    check("R6 drained", {31'b0, fast ? fiq_out : irq_out}, 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, mp, mk;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, d); check("R1 pending", d, 0);
    rd(8'h04, d); check("R1 mask", d, 32'hFFFF_FFFF);
    rd(8'h30, d); check("R1 cfg", d, 0);
    check("R1 outputs", {30'b0, irq_out, fiq_out}, 0);

    // R9 config sweep
    for (int n = 0; n < 32; n++) wr(8'h1C + 8'(4*n), 32'(((n*7)%32) << 2 | (n%2) << 1 | (n/2)%2) | 32'hFFFF_FF80);
    for (int n = 0; n < 32; n++) begin
      rd(8'h1C + 8'(4*n), d);
      check("R9 cfg readback", d, 32'(((n*7)%32) << 2 | (n%2) << 1 | (n/2)%2));
    end
    rd(8'h08, d); check("R9 undefined", d, 0);
    rd(8'h18, d); check("R6 control reads 0", d, 0);
    for (int n = 0; n < 32; n++) wr(8'h1C + 8'(4*n), 0);

    // R2 edge sweep
    for (int i = 0; i < 32; i++) begin
      pulse(32'h1 << i);
      rd(8'h00, d); check("R2 edge latched after fall", d, 32'h1 << i);
      wr(8'h00, 0);
      @(negedge clk); irq_in = 32'h1 << i;
      @(negedge clk);
      wr(8'h00, 0);
      rd(8'h00, d); check("R2 no reset while held high", d, 0);
      irq_in = 0;
    end

    // R8 software trigger
    wr(8'h9C, 32'h00F0_0100);
    rd(8'h00, d); check("R8 lowest bit", d, 32'h0000_0100);
    wr(8'h9C, 32'h8000_0000);
    rd(8'h00, d); check("R8 second", d, 32'h8000_0100);
    rd(8'h9C, d); check("R8 reads 0", d, 0);
    wr(8'h00, 32'h8000_0000);
    rd(8'h00, d); check("R4 AND edge", d, 32'h8000_0000);
    wr(8'h00, 0);

    // R3/R4 level sweep
    for (int i = 0; i < 32; i++) begin
      wr(8'h1C + 8'(4*i), 32'h2);
      @(negedge clk); irq_in = 32'h1 << i;
      @(negedge clk);
      rd(8'h00, d); check("R3 level set", d, 32'h1 << i);
      wr(8'h00, 0);
      rd(8'h00, d); check("R4 level high kept", d, 32'h1 << i);
      irq_in = 0;
      @(negedge clk);
      rd(8'h00, d); check("R3 level cleared", d, 0);
      wr(8'h1C + 8'(4*i), 0);
    end

    // R5/R6/R7 arbitration patterns
    for (int k = 0; k < 4; k++) begin
      logic [31:0] pats [4];
      pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5C3_1E87; pats[2] = 32'h0F0F_F0F0; pats[3] = 32'h8001_7FFE;
      bst = '0;
      for (int n = 0; n < 32; n++) begin
        bp[n] = (n*(2*k+5)+k) % (4 << k);
        bst[n] = ((n + k) % 3 == 0);
        wr(8'h1C + 8'(4*n), 32'(bp[n] << 2) | {31'b0, bst[n]});
      end
      mk = (k == 0) ? 32'h0 : (32'h0000_00FF << (8*(k-1)));
      wr(8'h00, 0);
      wr(8'h04, mk);
      mp = pats[k];
      pulse(mp);
      drain(0, mp, mk);
      drain(1, mp, mk);
      rd(8'h00, d); check("R5 masked remain", d, mp);
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h00, 0);
    end

    // R7 level ack keeps pending
    wr(8'h1C + 8'd12, 32'h3);
    wr(8'h04, ~(32'h1 << 3));
    @(negedge clk); irq_in = 32'h8;
    repeat (2) @(negedge clk);
    check("R6 fiq raised", {31'b0, fiq_out}, 1);
    rd(8'h14, d); check("R7 fiq code", d, 3);
    rd(8'h00, d); check("R7 level not acked", d, 32'h8);
    irq_in = 0;
    wr(8'h18, 32'h2);
    @(negedge clk);
    check("R6 fiq dropped", {31'b0, fiq_out}, 0);
    rd(8'h00, d); check("R3 cleared", d, 0);

    // R7 ack coinciding with new edge
    wr(8'h1C + 8'd12, 0);
    wr(8'h1C + 8'(4*9), 0);
    wr(8'h04, ~(32'h1 << 9));
    pulse(32'h1 << 9);
    check("R6 irq raised", {31'b0, irq_out}, 1);
    @(negedge clk); rd_en = 1; addr = 8'h10; irq_in = 32'h1 << 9; #1 d = rdata;
    @(negedge clk); rd_en = 0; irq_in = 0;
    check("R7 code", d, 9);
    rd(8'h00, d); check("R7 edge wins over ack", d, 32'h1 << 9);
    rd(8'h10, d);
    rd(8'h00, d); check("R7 edge acked", d, 0);
    wr(8'h10, 32'h3);
    wr(8'h14, 32'h5);
    rd(8'h10, d); check("R9 code write ignored", d, 9);
    rd(8'h14, d); check("R9 fcode write ignored", d, 3);
    wr(8'h18, 32'h1);
    @(negedge clk);
    check("R6 irq dropped", {31'b0, irq_out}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule